// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block watches the command pins of a two-bank synchronous DRAM and keeps its own model of what each bank is doing. The model covers idle, row activation in progress, row open, read burst with automatic precharge, write burst with automatic precharge, write recovery, and precharge in progress. Timed states are left by per-bank down-counters. The counters are loaded from parameters for the activate-to-column delay (`T_RCD`), the precharge time (`T_RP`), the write recovery time (`T_WR`) and the burst length in cycles (`BURST`).

Every clock, the checker decodes the command and judges it against the state of the bank it targets. Refresh, mode-register set and burst terminate have no target bank, so they are judged against both banks. One cycle later the checker reports the decoded command. If the command was illegal, it also raises a one-cycle error flag with a reason code. An illegal command never changes the model. The block sits beside a memory controller or a bus model as a passive monitor.

The timed parameters must satisfy `T_RCD >= 2`, `T_RP >= 2`, `T_WR >= 1` and `BURST >= 1`.

Top module: `sdram_bank_guard`

## Requirements
- R1: One cycle after the pins are sampled, `cmd_o` shows the decoded command. The codes are: chip select high = 0 (deselect). With chip select low, {ras_n,cas_n,we_n} decodes as follows: 111 = 1 (no-op), 110 = 2 (burst stop), 101 = 3 (read), 100 = 4 (write), 011 = 5 (activate), 010 = 6 (precharge), 001 = 7 (refresh), 000 = 8 (mode set).
- R2: The bank state codes are 0 idle, 1 activating, 2 active, 3 read-autoprecharge, 4 write-autoprecharge, 5 write-recovery and 6 precharging. During and right after reset, both banks are idle and `cmd_o`, `err_o` and `err_code_o` are 0.
- R3: A legal activate issued in cycle n moves the bank to activating from cycle n+1 and to active at cycle n+T_RCD. While the bank is activating, read, write, activate and precharge to it are illegal.
- R4: Read and write are legal only when the target bank is active. A read or write with `ap` low leaves the bank active.
- R5: Activate is legal only when the target bank is idle. Activating the other bank while one bank runs an auto-precharge burst is legal.
- R6: Precharge is legal for an idle, active or precharging bank. Issued in cycle n to an active bank, it makes the bank precharging from n+1 and idle at n+T_RP. Precharge to an idle or precharging bank has no effect.
- R7: A read with `ap` high in cycle n puts the bank in read-autoprecharge for cycles n+1..n+BURST. The bank is then precharging and becomes idle at n+BURST+T_RP.
- R8: A write with `ap` high in cycle n puts the bank in write-autoprecharge for cycles n+1..n+BURST. It is then in write-recovery for T_WR cycles, then precharging, and becomes idle at n+BURST+T_WR+T_RP.
- R9: Burst stop is illegal while either bank is in a state other than idle or active. Refresh and mode set are illegal unless both banks are idle. For these commands, the state field of the reason code is bank 0's state if bank 0 causes the violation, otherwise bank 1's state.
- R10: An illegal command in cycle n raises `err_o` for exactly cycle n+1, with `err_code_o` = {command[3:0], state[2:0]}. The state field is the target bank's state at cycle n. Deselect and no-op never raise an error, and an illegal command changes no bank state.
- R11: Each bank has its own state and counter. A command to one bank never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 1 | Target bank |
| ap | input | 1 | Auto-precharge select (precharge-bit address line) |
| cmd_o | output | 4 | Decoded command, one cycle late |
| st0_o | output | 3 | Bank 0 state |
| st1_o | output | 3 | Bank 1 state |
| err_o | output | 1 | Illegal-command pulse |
| err_code_o | output | 7 | Reason code {command, state} |

## Verification
The hardest situation to reach is a bank caught inside a short transient window. Examples are a bank that is still in write recovery after its auto-precharge write burst, or one whose auto-precharge read has just handed over to precharging while the other bank is mid-activation. The stimulus opens a row, then issues commands on a cycle-exact schedule counted from the parameters. Each offending command lands on a known cycle of each timed state. The schedule also places refresh and mode set at moments when only one of the two banks is busy, to show which bank the reason code blames.

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_WR  = 2,
  parameter int BURST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       bank,
  input  logic       ap,
  output logic [3:0] cmd_o,
  output logic [2:0] st0_o,
  output logic [2:0] st1_o,
  output logic       err_o,
  output logic [6:0] err_code_o
);
  localparam logic [3:0] C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3, C_WR = 4'd4,
                         C_ACT = 4'd5, C_PRE = 4'd6, C_REF = 4'd7, C_MRS = 4'd8;
  localparam logic [2:0] S_IDLE = 3'd0, S_OPEN = 3'd1, S_ACT = 3'd2, S_RDA = 3'd3,
                         S_WRA = 3'd4, S_WREC = 3'd5, S_PRE = 3'd6;
  localparam int MAXA = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int MAXB = (T_WR > BURST) ? T_WR : BURST;
  localparam int MAXD = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW   = $clog2(MAXD + 1);

  logic [2:0] st [2];
  logic [CW-1:0] cnt [2];
  logic [3:0] cmd;
  logic [2:0] tst, code_st;
  logic bad, tr0, tr1;

  assign cmd = cs_n ? 4'd0 : 4'd8 - {1'b0, ras_n, cas_n, we_n};
  assign tst = st[bank];
  assign tr0 = (st[0] != S_IDLE) && (st[0] != S_ACT);
  assign tr1 = (st[1] != S_IDLE) && (st[1] != S_ACT);

  always_comb begin
    bad = 1'b0;
    code_st = tst;
    case (cmd)
      C_RD, C_WR: bad = (tst != S_ACT);
      C_ACT:      bad = (tst != S_IDLE);
      C_PRE:      bad = !((tst == S_IDLE) || (tst == S_ACT) || (tst == S_PRE));
      C_BST: begin
        bad = tr0 || tr1;
        code_st = tr0 ? st[0] : st[1];
      end
      C_REF, C_MRS: begin
        bad = (st[0] != S_IDLE) || (st[1] != S_IDLE);
        code_st = (st[0] != S_IDLE) ? st[0] : st[1];
      end
      default: bad = 1'b0;
    endcase
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic hit;
    assign hit = (bank == 1'(b)) && !bad;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[b]  <= S_IDLE;
        cnt[b] <= '0;
      end else begin
        case (st[b])
          S_IDLE: if (hit && cmd == C_ACT) begin
            st[b]  <= S_OPEN;
            cnt[b] <= CW'(T_RCD - 1);
          end
          S_ACT: if (hit) begin
            if (cmd == C_RD && ap) begin
              st[b] <= S_RDA;  cnt[b] <= CW'(BURST);
            end else if (cmd == C_WR && ap) begin
              st[b] <= S_WRA;  cnt[b] <= CW'(BURST);
            end else if (cmd == C_PRE) begin
              st[b] <= S_PRE;  cnt[b] <= CW'(T_RP - 1);
            end
          end
          default: if (cnt[b] <= CW'(1)) begin
            case (st[b])
              S_OPEN:  st[b] <= S_ACT;
              S_RDA:   begin st[b] <= S_PRE;  cnt[b] <= CW'(T_RP - 1); end
              S_WRA:   begin st[b] <= S_WREC; cnt[b] <= CW'(T_WR); end
              S_WREC:  begin st[b] <= S_PRE;  cnt[b] <= CW'(T_RP - 1); end
              default: st[b] <= S_IDLE;
            endcase
          end else begin
            cnt[b] <= cnt[b] - CW'(1);
          end
        endcase
      end
    end

    p_open_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st[b] == S_OPEN |=> (st[b] == S_OPEN || st[b] == S_ACT));
    p_idle_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st[b] == S_IDLE && !(hit && cmd == C_ACT)) |=> st[b] == S_IDLE);
    p_rda_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st[b] == S_RDA |=> (st[b] == S_RDA || st[b] == S_PRE));
    p_wra_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st[b] == S_WRA |=> (st[b] == S_WRA || st[b] == S_WREC));
    p_wrec_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st[b] == S_WREC |=> (st[b] == S_WREC || st[b] == S_PRE));
    p_pre_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st[b] == S_PRE |=> (st[b] == S_PRE || st[b] == S_IDLE));
    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st[b] <= S_PRE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o      <= '0;
      err_o      <= 1'b0;
      err_code_o <= '0;
    end else begin
      cmd_o      <= cmd;
      err_o      <= bad;
      err_code_o <= bad ? {cmd, code_st} : 7'd0;
    end
  end

  assign st0_o = st[0];
  assign st1_o = st[1];

  p_err_not_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cmd_o != 4'd0 && cmd_o != C_NOP));
  p_err_code_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> err_code_o[6:3] == cmd_o);
  p_bad_freezes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && st[0] == S_ACT && st[1] == S_ACT) |=> (st[0] == S_ACT && st[1] == S_ACT));
endmodule

// File: tb/sdram_bank_guard_test.sv
`timescale 1ns/1ps
module sdram_bank_guard_test;
  localparam int RCD = 3, RP = 3, WR = 2, BL = 4;
  localparam logic [3:0] DSL = 0, NOP = 1, BST = 2, RD = 3, WRT = 4, ACT = 5,
                         PRE = 6, REF = 7, MRS = 8;
  localparam logic [2:0] S_I = 0, S_G = 1, S_A = 2, S_RA = 3, S_WA = 4, S_WR = 5, S_P = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, bank = 1'b0, ap = 1'b0;
  logic [3:0] cmd_o;
  logic [2:0] st0_o, st1_o;
  logic err_o;
  logic [6:0] err_code_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] qv[$];
  string qt[$];

  sdram_bank_guard #(.T_RCD(RCD), .T_RP(RP), .T_WR(WR), .BURST(BL)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .ap(ap), .cmd_o(cmd_o), .st0_o(st0_o),
    .st1_o(st1_o), .err_o(err_o), .err_code_o(err_code_o));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic b, input logic a,
                       input logic bad, input logic [2:0] s, input string tag);
    logic [3:0] rcw;
    rcw = 4'd8 - c;
    cs_n = (c == DSL);
    {ras_n, cas_n, we_n} = (c == DSL) ? 3'b111 : rcw[2:0];
    bank = b;
    ap = a;
    qv.push_back({c, bad, s});
    qt.push_back(tag);
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(NOP, 1'b0, 1'b0, 1'b0, 3'd0, "R10 nop");
  endtask

  task automatic st_is(input logic b, input logic [2:0] e, input string tag);
    logic [2:0] a;
    a = b ? st1_o : st0_o;
    chk(a == e, tag, a, e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (qv.size() > 0) begin
        logic [7:0] v;
        string t;
        v = qv.pop_front();
        t = qt.pop_front();
        chk(cmd_o == v[7:4], {t, " R1 cmd"}, cmd_o, v[7:4]);
        chk(err_o == v[3], {t, " R10 err"}, err_o, v[3]);
        if (v[3]) chk(err_code_o == {v[7:4], v[2:0]}, {t, " R10 code"}, err_code_o, {v[7:4], v[2:0]});
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st0_o == S_I && st1_o == S_I, "R2 reset states", {st1_o, st0_o}, 0);
    chk(err_o == 0 && cmd_o == 0 && err_code_o == 0, "R2 reset outputs", {err_o, cmd_o}, 0);
    rst_n = 1'b1;
    // R1 decode of legal commands with both banks idle
    issue(DSL, 0, 0, 0, 0, "R1 desel");
    issue(NOP, 0, 0, 0, 0, "R1 nop");
    issue(REF, 0, 0, 0, 0, "R9 ref idle");
    issue(MRS, 0, 0, 0, 0, "R9 mrs idle");
    issue(BST, 0, 0, 0, 0, "R9 bst idle");
    issue(PRE, 0, 0, 0, 0, "R6 pre idle");
    st_is(0, S_I, "R6 pre idle no effect");
    // R4 column commands to idle banks
    issue(RD, 0, 0, 1, S_I, "R4 read idle");
    issue(WRT, 1, 0, 1, S_I, "R4 write idle");
    // R3 activation window
    issue(ACT, 0, 0, 0, 0, "R3 act");
    st_is(0, S_G, "R3 activating");
    issue(RD, 0, 0, 1, S_G, "R3 read early");
    issue(PRE, 0, 0, 1, S_G, "R3 pre early");
    st_is(0, S_A, "R3 active at tRCD");
    issue(ACT, 0, 0, 1, S_A, "R5 act active");
    issue(RD, 0, 0, 0, 0, "R4 read active");
    issue(WRT, 0, 0, 0, 0, "R4 write active");
    st_is(0, S_A, "R4 stays active");
    // R11 other bank opens independently
    issue(ACT, 1, 0, 0, 0, "R11 act b1");
    st_is(1, S_G, "R11 b1 activating");
    st_is(0, S_A, "R11 b0 untouched");
    // R7 read with auto-precharge
    issue(RD, 0, 1, 0, 0, "R7 reada");
    st_is(0, S_RA, "R7 rda state");
    issue(RD, 0, 0, 1, S_RA, "R7 read in rda");
    issue(ACT, 0, 0, 1, S_RA, "R5 act same bank rda");
    issue(REF, 0, 0, 1, S_RA, "R9 ref busy b0");
    issue(BST, 0, 0, 1, S_RA, "R9 bst in rda");
    st_is(0, S_P, "R7 precharging after burst");
    st_is(1, S_A, "R11 b1 active");
    issue(PRE, 0, 0, 0, 0, "R6 pre in precharging");
    issue(MRS, 0, 0, 1, S_P, "R9 mrs precharging");
    st_is(0, S_I, "R7 idle at n+BL+tRP");
    // R6 explicit precharge
    issue(PRE, 1, 0, 0, 0, "R6 pre b1");
    st_is(1, S_P, "R6 b1 precharging");
    issue(ACT, 1, 0, 1, S_P, "R5 act precharging");
    issue(REF, 0, 0, 1, S_P, "R9 ref busy b1");
    st_is(1, S_I, "R6 idle at tRP");
    // R8 write with auto-precharge
    issue(ACT, 0, 0, 0, 0, "R8 act b0");
    nops(RCD - 1);
    st_is(0, S_A, "R8 open");
    issue(WRT, 0, 1, 0, 0, "R8 writea");
    issue(ACT, 1, 0, 0, 0, "R5 act other bank in wra");
    issue(WRT, 0, 0, 1, S_WA, "R8 write in wra");
    st_is(0, S_WA, "R8 wra state");
    issue(DSL, 0, 0, 0, 0, "R10 desel in burst");
    issue(NOP, 0, 0, 0, 0, "R10 nop in burst");
    st_is(0, S_WR, "R8 write recovery");
    issue(PRE, 0, 0, 1, S_WR, "R8 pre in wrec");
    issue(RD, 0, 0, 1, S_WR, "R8 read in wrec");
    st_is(0, S_P, "R8 precharging");
    nops(RP - 1);
    st_is(0, S_I, "R8 idle at n+BL+tWR+tRP");
    st_is(1, S_A, "R11 b1 active");
    issue(BST, 1, 0, 0, 0, "R9 bst no transient");
    issue(PRE, 1, 0, 0, 0, "R6 pre b1");
    nops(RP - 1);
    st_is(1, S_I, "R6 b1 idle");
    nops(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule